// File: doc/BRIEF.md
# Hi-Res Video Byte Capture

This block sits on a Z80-style bus next to a character-based video controller and turns it into a bitmap display. When the CPU runs the display file from the upper half of the address space, every opcode fetch there returns a byte of pixel data. The block samples that byte into a holding register late in the fetch and, in graphics mode, pulls the two top data bits low. The video controller then reads the fetch as a no-operation, since it takes any byte with both top bits clear as a NOP. In the refresh slot that follows, the block puts the held byte back on the data bus so the pixel shifter can load it. The row address therefore comes from the program counter, not from the refresh register pair.

All bus strobes are active low. They are sampled by a fast system clock together with the level of the CPU clock. The block drives the data bus through a per-bit output enable. While it drives, it raises a memory inhibit so that no memory device contends with it. The read buffer for off-board memory is enabled only for memory cycles in which the block is silent.

Top module: `hiResCapture`

## Requirements
- R1: On each system clock edge where mreqN=0, rfshN=1 and cpuClk=0, the holding register loads dIn. At all other edges it keeps its value.
- R2: While gfxEn=1 and rfshN=0, dOe is 8'hFF and dOut equals the holding register. On any bit where dOe is 0, dOut reads 0.
- R3: While gfxEn=1, a15=1, m1N=0 and no refresh drive is active, dOe is 8'hC0 and dOut is 8'h00. Bits 7 and 6 are driven low and the lower six bits are released. With a15=0 there is no forcing.
- R4: If the refresh drive and the forcing condition are both true, the refresh drive wins (dOe=8'hFF).
- R5: memInhibit is 1 exactly when at least one dOe bit is 1.
- R6: extBufEn is 1 exactly when mreqN=0 and dOe is all zero.
- R7: With gfxEn=0, dOe stays 0 and D7/D6 pass unforced. The holding register still loads as in R1, and a later refresh with gfxEn=1 replays that byte.
- R8: The refresh drive is combinational. In the same system clock cycle in which rfshN returns to 1, dOe drops to 0 unless R3 applies.
- R9: After reset (rstN=0) the holding register is 8'h00 and, with gfxEn=0, nothing is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuClk | input | 1 | Level of the CPU clock |
| mreqN | input | 1 | Memory request, active low |
| m1N | input | 1 | Opcode fetch, active low |
| rfshN | input | 1 | Refresh cycle, active low |
| a15 | input | 1 | Top address bit |
| gfxEn | input | 1 | Graphics mode enable |
| dIn | input | 8 | Data bus as seen by the block |
| dOut | output | 8 | Value the block drives on the data bus |
| dOe | output | 8 | Per-bit drive enable for the data bus |
| memInhibit | output | 1 | Disables all memory chip selects |
| extBufEn | output | 1 | Enables the off-board memory read buffer |

## Verification
The only stored state is the holding register. A wrong capture window or a stale byte does not show at fetch time. It shows in the next refresh slot with graphics on, as a wrong value on dOut, usually a few CPU T-states later. A wrong drive decision shows at once, in the same system cycle, on dOe, memInhibit and extBufEn. The bench therefore compares all four outputs against a behavioural model every cycle. It also checks the replayed byte after each structured fetch.

// File: rtl/hrPkg.sv
package hrPkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic capLoad;   // sample data bus into holding register
    logic driveAll;  // replay held byte on all bits
    logic forceTop;  // pull top bits low to fake a NOP
  } hrStrobes_t;
endpackage

// File: rtl/hrCtrl.sv
module hrCtrl
  import hrPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuClk,
  input  logic       mreqN,
  input  logic       m1N,
  input  logic       rfshN,
  input  logic       a15,
  input  logic       gfxEn,
  output hrStrobes_t strobes,
  output logic       memInhibit,
  output logic       extBufEn
);
  logic refreshSlot;
  logic videoFetch;

  always_comb begin
    refreshSlot      = !rfshN;
    videoFetch       = a15 && !m1N;
    strobes.capLoad  = !mreqN && rfshN && !cpuClk;
    strobes.driveAll = gfxEn && refreshSlot;
    strobes.forceTop = gfxEn && videoFetch && !strobes.driveAll;
    memInhibit       = strobes.driveAll || strobes.forceTop;
    extBufEn         = !mreqN && !memInhibit;
  end

  // R4
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.driveAll && strobes.forceTop));

  // R7
  gfx_off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !gfxEn |-> !memInhibit);
endmodule

// File: rtl/hrData.sv
module hrData
  import hrPkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NOP_BITS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  hrStrobes_t        strobes,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic [DATA_W-1:0] dOe
);
  localparam logic [DATA_W-1:0] ALL_ONES  = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] FORCE_MSK =
    ALL_ONES << (DATA_W - NOP_BITS);

  logic [DATA_W-1:0] capReg;

  always_ff @(posedge clk) begin
    if (!rstN)                capReg <= '0;
    else if (strobes.capLoad) capReg <= dIn;
  end

  always_comb begin
    if (strobes.driveAll) begin
      dOe  = ALL_ONES;
      dOut = capReg;
    end else if (strobes.forceTop) begin
      dOe  = FORCE_MSK;
      dOut = '0;
    end else begin
      dOe  = '0;
      dOut = '0;
    end
  end

  // R1
  capture_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capLoad |=> capReg == $past(dIn));

  // R1
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capLoad |=> $stable(capReg));

  // R2
  undriven_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dOut & ~dOe) == '0);
endmodule

// File: rtl/hiResCapture.sv
module hiResCapture
  import hrPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuClk,
  input  logic       mreqN,
  input  logic       m1N,
  input  logic       rfshN,
  input  logic       a15,
  input  logic       gfxEn,
  input  logic [7:0] dIn,
  output logic [7:0] dOut,
  output logic [7:0] dOe,
  output logic       memInhibit,
  output logic       extBufEn
);
  hrStrobes_t strobes;

  hrCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .cpuClk(cpuClk), .mreqN(mreqN), .m1N(m1N),
    .rfshN(rfshN), .a15(a15), .gfxEn(gfxEn), .strobes(strobes),
    .memInhibit(memInhibit), .extBufEn(extBufEn)
  );

  hrData #(.DATA_W(8), .NOP_BITS(2)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dIn(dIn),
    .dOut(dOut), .dOe(dOe)
  );

  // R5
  inhibit_matches_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    memInhibit == (dOe != 8'h00));

  // R6
  extbuf_no_contention_chk: assert property (@(posedge clk) disable iff (!rstN)
    extBufEn |-> (!mreqN && dOe == 8'h00));

  // R3
  force_top_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gfxEn && a15 && !m1N && rfshN) |-> (dOe == 8'hC0 && dOut == 8'h00));

  // R8
  release_on_rfsh_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rfshN && !(gfxEn && a15 && !m1N)) |-> dOe == 8'h00);
endmodule

// File: tb/test_hiResCapture.sv
`timescale 1ns/1ps
module test_hiResCapture;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuClk = 1'b1, mreqN = 1'b1, m1N = 1'b1, rfshN = 1'b1;
  logic a15 = 1'b0, gfxEn = 1'b0;
  logic [7:0] dIn = 8'h00;
  logic [7:0] dOut, dOe;
  logic memInhibit, extBufEn;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [7:0] expCap = 8'h00;

  always #2 clk = ~clk;

  hiResCapture i_hiResCapture (
    .clk(clk), .rstN(rstN), .cpuClk(cpuClk), .mreqN(mreqN), .m1N(m1N),
    .rfshN(rfshN), .a15(a15), .gfxEn(gfxEn), .dIn(dIn), .dOut(dOut),
    .dOe(dOe), .memInhibit(memInhibit), .extBufEn(extBufEn)
  );

  // Reference model of the holding register (R1, R9)
  always @(posedge clk) begin
    if (!rstN) expCap <= 8'h00;
    else if (mreqN == 1'b0 && rfshN == 1'b1 && cpuClk == 1'b0) expCap <= dIn;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Compare all outputs against the model (after the edge, before new inputs)
  task automatic compareAll();
    bit drv, frc;
    logic [7:0] eOe, eOut;
    drv = gfxEn && !rfshN;
    frc = gfxEn && a15 && !m1N && !drv;
    eOe  = drv ? 8'hFF : (frc ? 8'hC0 : 8'h00);
    eOut = drv ? expCap : 8'h00;
    chk("R2 R3 R4 R7 R8 dOe", dOe, eOe);
    chk("R1 R2 R3 dOut", dOut, eOut);
    chk("R5 memInhibit", {7'b0, memInhibit}, {7'b0, drv || frc});
    chk("R6 extBufEn", {7'b0, extBufEn}, {7'b0, !mreqN && !drv && !frc});
  endtask

  task automatic tick();
    @(negedge clk);
    compareAll();
  endtask

  task automatic phase(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  // One opcode fetch followed by its refresh slot
  task automatic fetchCycle(input logic addrHi, input logic [7:0] b, input logic [7:0] junk);
    cpuClk = 1; m1N = 0; mreqN = 1; a15 = addrHi; dIn = junk;  phase(2);
    cpuClk = 0; mreqN = 0;                                     phase(2);
    cpuClk = 1; dIn = b;                                       phase(2);
    cpuClk = 0;                                                phase(2);
    cpuClk = 1; m1N = 1; mreqN = 1; rfshN = 0; dIn = junk;     phase(2);
    cpuClk = 0; mreqN = 0;                                     phase(1);
    if (gfxEn) chk("R1 R2 replay", dOut, b);
    phase(1);
    cpuClk = 1;                                                phase(2);
    cpuClk = 0; mreqN = 1;                                     phase(2);
    rfshN = 1; a15 = 0;                                        tick();
    chk("R8 release", dOe, 8'h00);
  endtask

  initial begin
    phase(3);
    chk("R9 reset dOe", dOe, 8'h00);
    chk("R9 reset dOut", dOut, 8'h00);
    rstN = 1;
    gfxEn = 1;
    cpuClk = 1; rfshN = 0; tick();
    chk("R9 reset register replay", dOut, 8'h00);
    rfshN = 1; tick();

    // Graphics on, video fetches
    for (int i = 0; i < 200; i++) fetchCycle(1'b1, 8'($urandom), 8'($urandom));
    // Low half fetch: no forcing
    for (int i = 0; i < 50; i++) fetchCycle(1'b0, 8'($urandom), 8'($urandom));

    // R7: graphics off still captures, replay after enabling
    gfxEn = 0;
    fetchCycle(1'b1, 8'h5A, 8'h33);
    gfxEn = 1; cpuClk = 1; rfshN = 0; tick();
    chk("R7 capture while off", dOut, 8'h5A);
    rfshN = 1; tick();

    // R4: both conditions at once
    a15 = 1; m1N = 0; rfshN = 0; tick();
    chk("R4 priority", dOe, 8'hFF);
    m1N = 1; rfshN = 1; a15 = 0; tick();

    // Unconstrained random patterns
    for (int i = 0; i < 4000; i++) begin
      {cpuClk, mreqN, m1N, rfshN, a15} = 5'($urandom);
      gfxEn = ($urandom % 4) != 0;
      dIn = 8'($urandom);
      if (i % 997 == 500) rstN = 0; else rstN = 1;
      tick();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule